// File: doc/BRIEF.md
# Reset and Boot Sequencing Controller

This block walks a chip from power-up to running code. It waits in a power-on hold until both the supply-above-threshold flag and the regulated-supply-safe flag from the low-voltage detector are high. It then steps through a fixed sequence. First it asserts the internal system reset and pulls the open-drain reset pin low. Next it enables the clock generator in its default mode. After that it turns on the core, system, flash and default-on bus clocks. Last it takes the flash controller out of reset with a one-cycle init-start pulse.

While flash initialisation runs, the controller captures the non-volatile option byte into an option register. Two bits of that byte act on the reset exit. One bit chooses the four reset-exit clock divider values. The other bit chooses whether flash init runs on the slow clock. When the flash reports done, the controller stops driving the pin and waits for the pin to read high through a two-flop synchronizer. This wait covers slow rising edges and boards that hold the pin low. Only then does it release the core and drop the system reset. At that edge it samples a synchronized boot-select input, which is active low, to choose serial programming mode over normal execution. If either supply flag drops at any time, the controller returns at once to the power-on hold.

Top module: `boot_seq_ctrl`

## Requirements
- R1: After the synchronous reset `rst`:
  - `sys_rst`, `pin_oe` and `flash_rst` are 1.
  - `clkgen_en`, `clk_en`, `init_start`, `core_release` and `serial_prog` are 0.
  - `opt_reg` is 0.
  - `div_bus` is 16'hFF77.
  - `slow_init` is 0.
- R2: While `supply_ok` or `vdet_ok` is low, the block stays in hold: `sys_rst`=1, `pin_oe`=1, `clkgen_en`=0, `clk_en`=0 and `flash_rst`=1.
- R3: Once both supply flags are high, the block spends exactly one cycle in the reset-assert step and one cycle with only `clkgen_en` set. Then `clk_en` becomes {bus gate defaults, 3'b111}, which is 5'b01111 by default. Bit 0 of `clk_en` is core, bit 1 is system, bit 2 is flash, and bits 3 and up are the bus clocks. `sys_rst` and `pin_oe` stay 1 throughout.
- R4: The cycle after the clocks come on, `flash_rst` falls and `init_start` is high for exactly one cycle. `sys_rst` and `pin_oe` stay 1.
- R5: After init-start, the first `opt_valid` captures `opt_data` into `opt_reg`.
- R6: If bit 0 of the captured byte is 0, `div_bus` becomes 16'hFF77. The fields are core/system in [3:0]=7, bus in [7:4]=7, external bus in [11:8]=15 and flash in [15:12]=15.
- R7: If bit 0 of the captured byte is 1, `div_bus` becomes 16'h1100. That is core/system=0, bus=0, external bus=1 and flash=1.
- R8: `slow_init` equals the inverse of bit 1 of the captured byte.
- R9: With the byte captured, `flash_done` high makes `pin_oe` fall. While the pin reads low, `sys_rst` stays 1 and `core_release` stays 0.
- R10: Within four cycles of the pin reading high, `core_release` rises and `sys_rst` falls.
- R11: `serial_prog` is set at core release to the inverse of the synchronized `boot_sel_n`. After that it holds, and `div_bus` holds, while the core runs.
- R12: If either supply flag falls at any step, the next cycle shows the hold outputs of R2, with `core_release`=0 and `serial_prog`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above the power-on threshold |
| vdet_ok | input | 1 | Regulated supply safe, from the low-voltage detector |
| pin_level | input | 1 | Sensed level of the reset pin (asynchronous) |
| boot_sel_n | input | 1 | Boot-mode select, active low (asynchronous) |
| opt_valid | input | 1 | Option byte valid strobe |
| opt_data | input | 8 | Option byte from non-volatile memory |
| flash_done | input | 1 | Flash initialisation complete (level) |
| sys_rst | output | 1 | Internal system reset |
| pin_oe | output | 1 | Drives the open-drain reset pin low when 1 |
| clkgen_en | output | 1 | Clock generator enable, default mode |
| clk_en | output | 5 | Clock enables: core, system, flash, bus clocks |
| flash_rst | output | 1 | Flash controller reset |
| init_start | output | 1 | One-cycle flash init start |
| opt_reg | output | 8 | Captured option byte |
| div_bus | output | 16 | Four reset-exit divider fields |
| slow_init | output | 1 | Flash init on slow clock |
| core_release | output | 1 | Core released to run |
| serial_prog | output | 1 | Serial programming boot selected |

## Verification
The assertions assume several things about the inputs:
- The flash side gives `opt_valid` only after init-start.
- `flash_done` stays high once raised, until the next hold.
- The pin stays low while `pin_oe` is set, as an open-drain pin does.

The bench keeps to these assumptions. It models the pin as the wired AND of the controller's drive and an external hold-low source. It gives the option strobe only a few cycles after the observed init-start pulse. It raises `flash_done` only after the byte is captured. The supply flags are treated as synchronous status and change only away from the clock edge.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [3:0] {
    ST_POR,
    ST_RST,
    ST_CGEN,
    ST_CLKS,
    ST_FLREL,
    ST_OPT,
    ST_FLINIT,
    ST_PINREL,
    ST_RUN
  } seq_st_e;

  // Reset-exit divider code for field idx: 0 core/system, 1 bus, 2 ext bus, 3 flash
  function automatic logic [3:0] div_code(input int idx, input logic fast_mode);
    logic [3:0] v;
    if (fast_mode) v = (idx >= 2) ? 4'd1 : 4'd0;
    else           v = (idx >= 2) ? 4'd15 : 4'd7;
    return v;
  endfunction

endpackage

// File: rtl/bsc_sync.sv
module bsc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= rst_val;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bsc_opt_decode.sv
module bsc_opt_decode #(
  parameter int OPT_W     = 8,
  parameter int DIV_W     = 4,
  parameter int N_DIV     = 4,
  parameter int LPB_BIT   = 0,
  parameter int FAST_BIT  = 1,
  localparam int BUS_W    = DIV_W * N_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [OPT_W-1:0] opt_in,
  output logic [OPT_W-1:0] opt_reg,
  output logic [BUS_W-1:0] div_bus,
  output logic             slow_init
);
  import boot_seq_pkg::*;

  logic [BUS_W-1:0] fast_vals, slow_vals;

  genvar g;
  generate
    for (g = 0; g < N_DIV; g++) begin : g_div
      assign fast_vals[g*DIV_W +: DIV_W] = DIV_W'(div_code(g, 1'b1));
      assign slow_vals[g*DIV_W +: DIV_W] = DIV_W'(div_code(g, 1'b0));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_reg   <= '0;
      div_bus   <= slow_vals;
      slow_init <= 1'b0;
    end else if (take) begin
      opt_reg   <= opt_in;
      div_bus   <= opt_in[LPB_BIT] ? fast_vals : slow_vals;
      slow_init <= ~opt_in[FAST_BIT];
    end
  end
endmodule

// File: rtl/bsc_seq_fsm.sv
module bsc_seq_fsm #(
  parameter int              CLK_W       = 5,
  parameter logic [CLK_W-1:0] CLK_ON_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_ok,
  input  logic             opt_valid,
  input  logic             flash_done,
  input  logic             pin_hi,
  input  logic             bsel_lo,
  output logic             opt_take,
  output logic             sys_rst,
  output logic             pin_oe,
  output logic             clkgen_en,
  output logic [CLK_W-1:0] clk_en,
  output logic             flash_rst,
  output logic             init_start,
  output logic             core_release,
  output logic             serial_prog
);
  import boot_seq_pkg::*;

  seq_st_e st, nxt;

  assign opt_take = (st == ST_OPT) && opt_valid;

  always_comb begin
    nxt = st;
    if (!pwr_ok) nxt = ST_POR;
    else begin
      unique case (st)
        ST_POR:    nxt = ST_RST;
        ST_RST:    nxt = ST_CGEN;
        ST_CGEN:   nxt = ST_CLKS;
        ST_CLKS:   nxt = ST_FLREL;
        ST_FLREL:  nxt = ST_OPT;
        ST_OPT:    if (opt_valid)  nxt = ST_FLINIT;
        ST_FLINIT: if (flash_done) nxt = ST_PINREL;
        ST_PINREL: if (pin_hi)     nxt = ST_RUN;
        ST_RUN:    nxt = ST_RUN;
        default:   nxt = ST_POR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_POR;
      sys_rst      <= 1'b1;
      pin_oe       <= 1'b1;
      clkgen_en    <= 1'b0;
      clk_en       <= '0;
      flash_rst    <= 1'b1;
      init_start   <= 1'b0;
      core_release <= 1'b0;
      serial_prog  <= 1'b0;
    end else begin
      st           <= nxt;
      sys_rst      <= (nxt != ST_RUN);
      pin_oe       <= !(nxt inside {ST_PINREL, ST_RUN});
      clkgen_en    <= !(nxt inside {ST_POR, ST_RST});
      clk_en       <= (nxt inside {ST_POR, ST_RST, ST_CGEN}) ? '0 : CLK_ON_MASK;
      flash_rst    <= (nxt inside {ST_POR, ST_RST, ST_CGEN, ST_CLKS});
      init_start   <= (nxt == ST_FLREL);
      core_release <= (nxt == ST_RUN);
      if (nxt == ST_POR) serial_prog <= 1'b0;
      else if (st == ST_PINREL && nxt == ST_RUN) serial_prog <= bsel_lo;
    end
  end
endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl #(
  parameter int              OPT_W       = 8,
  parameter int              DIV_W       = 4,
  parameter int              N_DIV       = 4,
  parameter int              N_BUS       = 2,
  parameter logic [N_BUS-1:0] BUS_GATE_ON = 2'b01,
  parameter int              SYNC_STAGES = 2,
  parameter int              LPB_BIT     = 0,
  parameter int              FAST_BIT    = 1,
  localparam int             CLK_W       = 3 + N_BUS,
  localparam int             BUS_W       = DIV_W * N_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             supply_ok,
  input  logic             vdet_ok,
  input  logic             pin_level,
  input  logic             boot_sel_n,
  input  logic             opt_valid,
  input  logic [OPT_W-1:0] opt_data,
  input  logic             flash_done,
  output logic             sys_rst,
  output logic             pin_oe,
  output logic             clkgen_en,
  output logic [CLK_W-1:0] clk_en,
  output logic             flash_rst,
  output logic             init_start,
  output logic [OPT_W-1:0] opt_reg,
  output logic [BUS_W-1:0] div_bus,
  output logic             slow_init,
  output logic             core_release,
  output logic             serial_prog
);
  localparam logic [CLK_W-1:0] CLK_ON_MASK = {BUS_GATE_ON, 3'b111};

  logic [1:0] sync_q;
  logic       opt_take;

  bsc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .rst_val (2'b10),
    .d       ({boot_sel_n, pin_level}),
    .q       (sync_q)
  );

  bsc_seq_fsm #(.CLK_W(CLK_W), .CLK_ON_MASK(CLK_ON_MASK)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .pwr_ok       (supply_ok && vdet_ok),
    .opt_valid    (opt_valid),
    .flash_done   (flash_done),
    .pin_hi       (sync_q[0]),
    .bsel_lo      (~sync_q[1]),
    .opt_take     (opt_take),
    .sys_rst      (sys_rst),
    .pin_oe       (pin_oe),
    .clkgen_en    (clkgen_en),
    .clk_en       (clk_en),
    .flash_rst    (flash_rst),
    .init_start   (init_start),
    .core_release (core_release),
    .serial_prog  (serial_prog)
  );

  bsc_opt_decode #(
    .OPT_W(OPT_W), .DIV_W(DIV_W), .N_DIV(N_DIV),
    .LPB_BIT(LPB_BIT), .FAST_BIT(FAST_BIT)
  ) u_opt (
    .clk       (clk),
    .rst       (rst),
    .take      (opt_take),
    .opt_in    (opt_data),
    .opt_reg   (opt_reg),
    .div_bus   (div_bus),
    .slow_init (slow_init)
  );
endmodule

// File: rtl/boot_seq_ctrl_chk.sv
module boot_seq_ctrl_chk #(
  parameter int CLK_W = 5,
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             supply_ok,
  input logic             vdet_ok,
  input logic             sys_rst,
  input logic             pin_oe,
  input logic             clkgen_en,
  input logic [CLK_W-1:0] clk_en,
  input logic             flash_rst,
  input logic             init_start,
  input logic             core_release,
  input logic             serial_prog,
  input logic [BUS_W-1:0] div_bus
);
  // R2, R12: a supply flag low forces the hold outputs next cycle
  a_r2_hold_on_low_supply: assert property (@(posedge clk) disable iff (rst)
    !(supply_ok && vdet_ok) |=> (sys_rst && pin_oe && !clkgen_en && clk_en == '0 && flash_rst && !core_release));

  // R3: flash leaves reset only with clocks running
  a_r3_clocks_before_flash: assert property (@(posedge clk) disable iff (rst)
    !flash_rst |-> (clkgen_en && clk_en != '0));

  // R4: init pulse while system and pin still held
  a_r4_init_in_reset: assert property (@(posedge clk) disable iff (rst)
    init_start |-> (sys_rst && pin_oe && !flash_rst));

  // R4: init pulse lasts one cycle
  a_r4_init_one_cycle: assert property (@(posedge clk) disable iff (rst)
    init_start |=> !init_start);

  // R9: the pin is released only after the flash left reset
  a_r9_pin_after_flash: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !flash_rst);

  // R10: core release follows a cycle with the pin undriven
  a_r10_release_after_pin: assert property (@(posedge clk) disable iff (rst)
    $rose(core_release) |-> $past(!pin_oe));

  // R11: boot mode and dividers hold while running
  a_r11_stable_running: assert property (@(posedge clk) disable iff (rst)
    (core_release && $past(core_release)) |-> ($stable(serial_prog) && $stable(div_bus)));
endmodule

bind boot_seq_ctrl boot_seq_ctrl_chk #(.CLK_W(CLK_W), .BUS_W(BUS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .supply_ok    (supply_ok),
  .vdet_ok      (vdet_ok),
  .sys_rst      (sys_rst),
  .pin_oe       (pin_oe),
  .clkgen_en    (clkgen_en),
  .clk_en       (clk_en),
  .flash_rst    (flash_rst),
  .init_start   (init_start),
  .core_release (core_release),
  .serial_prog  (serial_prog),
  .div_bus      (div_bus)
);

// File: tb/boot_seq_ctrl_bench.sv
module boot_seq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        supply_ok = 1'b0, vdet_ok = 1'b0;
  logic        ext_hold = 1'b0;
  logic        boot_sel_n = 1'b1;
  logic        opt_valid = 1'b0;
  logic [7:0]  opt_data = '0;
  logic        flash_done = 1'b0;
  logic        pin_level;
  logic        sys_rst, pin_oe, clkgen_en, flash_rst, init_start;
  logic        slow_init, core_release, serial_prog;
  logic [4:0]  clk_en;
  logic [7:0]  opt_reg;
  logic [15:0] div_bus;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  // open-drain pin: low when the block drives it or a board source holds it
  assign pin_level = !(pin_oe || ext_hold);

  boot_seq_ctrl u_boot_seq_ctrl (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .vdet_ok(vdet_ok),
    .pin_level(pin_level), .boot_sel_n(boot_sel_n), .opt_valid(opt_valid),
    .opt_data(opt_data), .flash_done(flash_done), .sys_rst(sys_rst),
    .pin_oe(pin_oe), .clkgen_en(clkgen_en), .clk_en(clk_en),
    .flash_rst(flash_rst), .init_start(init_start), .opt_reg(opt_reg),
    .div_bus(div_bus), .slow_init(slow_init), .core_release(core_release),
    .serial_prog(serial_prog)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(1);
    chk("R1 sys_rst", sys_rst, 1);
    chk("R1 pin_oe", pin_oe, 1);
    chk("R1 flash_rst", flash_rst, 1);
    chk("R1 clk_en", {clkgen_en, clk_en}, 0);
    chk("R1 release", {init_start, core_release, serial_prog}, 0);
    chk("R1 opt_reg", opt_reg, 0);
    chk("R1 div_bus", div_bus, 32'hFF77);
    chk("R1 slow_init", slow_init, 0);
  endtask

  task automatic t_por_hold;
    supply_ok = 1'b1; vdet_ok = 1'b0;
    cyc(5);
    chk("R2 vdet low", {sys_rst, pin_oe, clkgen_en, flash_rst}, 4'b1101);
    chk("R2 vdet low clk", clk_en, 0);
    supply_ok = 1'b0; vdet_ok = 1'b1;
    cyc(5);
    chk("R2 supply low", {sys_rst, pin_oe, clkgen_en, flash_rst}, 4'b1101);
    supply_ok = 1'b0; vdet_ok = 1'b0;
    cyc(1);
  endtask

  // shared boot walk; scenario tasks pick the byte, pin hold and boot select
  task automatic boot_run(input logic [7:0] ob, input int hold, input logic bsel_n,
                          input logic [15:0] exp_div, input logic exp_slow);
    supply_ok = 1'b0; vdet_ok = 1'b0; flash_done = 1'b0;
    boot_sel_n = bsel_n; ext_hold = (hold > 0);
    cyc(2);
    supply_ok = 1'b1; vdet_ok = 1'b1;
    cyc(1);
    chk("R3 step rst", {sys_rst, pin_oe, clkgen_en}, 3'b110);
    cyc(1);
    chk("R3 step cgen", {clkgen_en, clk_en}, 6'b100000);
    cyc(1);
    chk("R3 step clks", clk_en, 5'b01111);
    chk("R3 still held", {sys_rst, pin_oe, flash_rst}, 3'b111);
    cyc(1);
    chk("R4 init start", {init_start, flash_rst, sys_rst, pin_oe}, 4'b1011);
    cyc(1);
    chk("R4 pulse end", init_start, 0);
    cyc(2);
    opt_data = ob; opt_valid = 1'b1;
    cyc(1);
    opt_valid = 1'b0; opt_data = 8'h00;
    cyc(1);
    chk("R5 opt_reg", opt_reg, ob);
    chk(ob[0] ? "R7 div_bus" : "R6 div_bus", div_bus, exp_div);
    chk("R8 slow_init", slow_init, exp_slow);
    flash_done = 1'b1;
    cyc(1);
    chk("R9 pin released", pin_oe, 0);
    if (hold > 0) begin
      cyc(hold);
      chk("R9 held by pin", {sys_rst, core_release}, 2'b10);
      ext_hold = 1'b0;
    end
    cyc(5);
    chk("R10 core released", {core_release, sys_rst}, 2'b10);
    chk("R11 boot mode", serial_prog, !bsel_n);
    boot_sel_n = !bsel_n;
    cyc(4);
    chk("R11 mode holds", serial_prog, !bsel_n);
    chk("R11 div holds", div_bus, exp_div);
  endtask

  task automatic t_boot_fast;     boot_run(8'h03, 0, 1'b1, 16'h1100, 1'b0); endtask
  task automatic t_boot_lowpower; boot_run(8'hA0, 0, 1'b1, 16'hFF77, 1'b1); endtask
  task automatic t_pin_hold;      boot_run(8'h01, 20, 1'b1, 16'h1100, 1'b1); endtask
  task automatic t_serial_mode;   boot_run(8'h02, 0, 1'b0, 16'hFF77, 1'b0); endtask

  task automatic t_brownout;
    boot_run(8'h03, 0, 1'b0, 16'h1100, 1'b0);
    vdet_ok = 1'b0;
    cyc(1);
    chk("R12 run drop", {sys_rst, pin_oe, core_release, serial_prog}, 4'b1100);
    chk("R12 clocks off", {clkgen_en, clk_en, flash_rst}, 7'b0000001);
    // drop in the middle of flash init
    vdet_ok = 1'b1; flash_done = 1'b0;
    cyc(6);
    supply_ok = 1'b0;
    cyc(1);
    chk("R12 mid drop", {sys_rst, pin_oe, clkgen_en, flash_rst, init_start}, 5'b11010);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    t_reset();
    t_por_hold();
    t_boot_lowpower();
    t_boot_fast();
    t_pin_hold();
    t_serial_mode();
    t_brownout();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule